// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one external interrupt pin of a small microcontroller and turns its activity into a sticky interrupt request. A 4-bit control register, written and read over a simple bus strobe, decides four things:
- whether the pin is looked at all;
- which level counts as active;
- whether one edge or both edges are detected;
- whether a detected edge should also start a linked timer.

The pin first passes through a two-flop synchronizer. The polarity choice is applied to the synchronized value, which gives an internal "active" signal. An edge on that active signal sets the request flag. The flag stays set until software pulses a clear strobe. The same active signal is also offered as a level-test output, so that a skip-on-level instruction can ask whether the pin currently sits at its active level.

The register is cleared only by reset and keeps its contents through power-down. A configuration write that flips the active signal counts as an edge and may raise the request flag. This side effect is kept on purpose.

Top module: `extint_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, the register reads 4'b0000, and the request flag, the timer-start pulse and the level-test output are all 0.
- R2: A write loads wr_data_i[3:0] into the register, and the new value is visible on rd_data_o after the clock edge that takes it. Without a write, the register holds its value indefinitely. Only reset clears it.
- R3: Register bit 3 enables the input. While bit 3 is 0, the level-test output is 0. A pin change that starts while bit 3 has been 0 for the whole synchronizer latency never sets the flag.
- R4: Register bit 2 selects polarity. At 0, the falling edge is the active edge and a low pin gives level-test 1. At 1, the rising edge is the active edge and a high pin gives level-test 1.
- R5: Register bit 1 selects the edge mode. At 0, only the edge chosen by bit 2 sets the flag. At 1, both rising and falling edges set the flag.
- R6: Register bit 0 links the timer. When a detected edge sets the flag, tmr_start_o is high for that one clock, in the same cycle the flag first reads 1. This happens only if bit 0 was 1 when the edge was seen; otherwise tmr_start_o stays 0.
- R7: A pin change reaches the level-test output after 2 rising clock edges. It reaches the flag and the timer pulse after 3 rising clock edges.
- R8: Once set, the flag stays 1 until flag_clr_i is high at a clock edge. If a set and a clear fall on the same edge, the flag ends up 1.
- R9: A write that changes bit 2 or bit 3 so that the active signal goes from 0 to 1 sets the flag one cycle after the register updates. In both-edge mode, a change from 1 to 0 sets it as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 4 | Register write data |
| rd_data_o | output | 4 | Register contents |
| flag_clr_i | input | 1 | Clear strobe for the request flag |
| irq_flag_o | output | 1 | Sticky interrupt request flag |
| level_hit_o | output | 1 | 1 when the enabled pin sits at its active level |
| tmr_start_o | output | 1 | One-cycle linked-timer start pulse |

## Verification
The assertions assume that reset is applied at start-up, and that the write and clear strobes are clean 0/1 values at each clock edge. They assume nothing about how fast the pin moves, because the pin is sampled only through the synchronizer. The bench drives the pin, the write strobe and the clear strobe only at the falling clock edge, so they always satisfy these assumptions. Its random phases then mix pin toggles at every spacing (including back-to-back changes), arbitrary register writes and clears that collide with sets. This covers the set-versus-clear race and the write-induced edges.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;

    // Register layout: bit3 input enable, bit2 polarity, bit1 both-edge, bit0 timer link
    typedef struct packed {
        logic in_en;
        logic pol_hi;
        logic both;
        logic tsync;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam cfg_t CFG_RESET = '{in_en: 1'b0, pol_hi: 1'b0, both: 1'b0, tsync: 1'b0};

    typedef struct packed {
        logic set;
        logic start;
    } evt_t;

    // Active level after polarity, forced low when disabled
    function automatic logic active_of(input cfg_t c, input logic s);
        if (!c.in_en) return 1'b0;
        return c.pol_hi ? s : ~s;
    endfunction

    // Edge decision between previous and current active value
    function automatic logic edge_of(input cfg_t c, input logic prev, input logic cur);
        return c.both ? (prev ^ cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/extint_cfg_reg.sv
`timescale 1ns/1ps
module extint_cfg_reg
    import extint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output cfg_t             cfg_o
);
    cfg_t cfg_q;

    // Only reset clears the register; it is otherwise retained
    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= CFG_RESET;
        else if (wr_en_i) cfg_q <= cfg_t'(wr_data_i);
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/extint_edge_flag.sv
`timescale 1ns/1ps
module extint_edge_flag
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_i,
    input  logic pin_s_i,
    input  logic clr_i,
    output logic flag_o,
    output logic start_o,
    output logic level_o
);
    logic act;
    logic act_q;
    evt_t evt;
    logic flag_q;
    logic start_q;

    // Polarity and enable are applied before the edge compare, so a
    // configuration change can itself look like an edge.
    assign act       = active_of(cfg_i, pin_s_i);
    assign evt.set   = edge_of(cfg_i, act_q, act);
    assign evt.start = evt.set & cfg_i.tsync;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            flag_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            act_q   <= act;
            start_q <= evt.start;
            if (evt.set)    flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign flag_o  = flag_q;
    assign start_o = start_q;
    assign level_o = act;
endmodule

// File: rtl/extint_detect.sv
`timescale 1ns/1ps
module extint_detect
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output logic [CFG_W-1:0] rd_data_o,
    input  logic             flag_clr_i,
    output logic             irq_flag_o,
    output logic             level_hit_o,
    output logic             tmr_start_o
);
    cfg_t cfg;
    logic pin_s;

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_s)
    );

    extint_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg)
    );

    extint_edge_flag u_det (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg),
        .pin_s_i (pin_s),
        .clr_i   (flag_clr_i),
        .flag_o  (irq_flag_o),
        .start_o (tmr_start_o),
        .level_o (level_hit_o)
    );

    assign rd_data_o = cfg;
endmodule

// File: rtl/extint_checks.sv
`timescale 1ns/1ps
module extint_checks (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic [3:0] wr_data_i,
    input logic [3:0] rd_data_o,
    input logic       flag_clr_i,
    input logic       irq_flag_o,
    input logic       level_hit_o,
    input logic       tmr_start_o
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: first cycle after reset is clean
    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            p_reset_state_r1: assert (rd_data_o == 4'b0000 && !irq_flag_o && !tmr_start_o && !level_hit_o)
                else $error("reset state wrong");
        end
    end

    p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> rd_data_o == $past(wr_data_i));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(rd_data_o));

    p_disabled_level_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_data_o[3] |-> !level_hit_o);

    p_start_has_flag_r6: assert property (@(posedge clk) disable iff (rst)
        tmr_start_o |-> irq_flag_o);

    p_start_needs_link_r6: assert property (@(posedge clk) disable iff (rst)
        tmr_start_o |-> $past(rd_data_o[0]));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_flag_o && !flag_clr_i) |=> irq_flag_o);
endmodule

bind extint_detect extint_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .flag_clr_i  (flag_clr_i),
    .irq_flag_o  (irq_flag_o),
    .level_hit_o (level_hit_o),
    .tmr_start_o (tmr_start_o)
);

// File: tb/sim_extint_detect.sv
`timescale 1ns/1ps
module sim_extint_detect;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic       clr = 1'b0;
    logic [3:0] rd_data;
    logic       flag, level, tstart;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    extint_detect u0 (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_data_o   (rd_data),
        .flag_clr_i  (clr),
        .irq_flag_o  (flag),
        .level_hit_o (level),
        .tmr_start_o (tstart)
    );

    // Reference state, built from the requirements
    logic [3:0] m_cfg;
    logic m_s1, m_s2, m_prev, m_flag, m_start;

    function automatic logic m_act(input logic [3:0] c, input logic s);
        if (!c[3]) return 1'b0;          // R3 enable
        return c[2] ? s : ~s;            // R4 polarity
    endfunction

    task automatic check(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "reg(R2)", rd_data, m_cfg);
        check(tag, "flag(R8)", {3'b0, flag}, {3'b0, m_flag});
        check(tag, "tstart(R6)", {3'b0, tstart}, {3'b0, m_start});
        check(tag, "level(R4)", {3'b0, level}, {3'b0, m_act(m_cfg, m_s2)});
    endtask

    // One clock: drive at negedge, advance model, sample at next negedge
    task automatic cyc(input logic p, input logic w, input logic [3:0] d, input logic c, input string tag);
        logic a, e, nf;
        pin = p; wr_en = w; wr_data = d; clr = c;
        a  = m_act(m_cfg, m_s2);
        e  = m_cfg[1] ? (a ^ m_prev) : (a & ~m_prev);   // R5 edge mode
        nf = e ? 1'b1 : (c ? 1'b0 : m_flag);              // R8 set wins
        m_start = e & m_cfg[0];                           // R6
        m_flag  = nf;
        m_prev  = a;
        m_s2    = m_s1;                                    // R7 two stages
        m_s1    = p;
        if (w) m_cfg = d;                                  // R2
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic hold(input int n, input logic p, input string tag);
        for (int i = 0; i < n; i++) cyc(p, 1'b0, 4'h0, 1'b0, tag);
    endtask

    task automatic wr(input logic [3:0] d, input string tag);
        cyc(pin, 1'b1, d, 1'b0, tag);
    endtask

    task automatic clear(input string tag);
        cyc(pin, 1'b0, 4'h0, 1'b1, tag);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_cfg = 4'h0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_start = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "reg in reset", rd_data, 4'h0);
        check("R1", "flag in reset", {3'b0, flag}, 4'h0);
        @(negedge clk);
        rst = 1'b0;
        // pin was high during reset: model synchronizer sees it
        hold(1, 1'b1, "R1");
        check("R1", "tstart after reset", {3'b0, tstart}, 4'h0);
        check("R1", "level after reset", {3'b0, level}, 4'h0);
        hold(3, 1'b1, "R3");

        // Disabled: pin toggles never set the flag
        hold(4, 1'b0, "R3"); hold(4, 1'b1, "R3");
        check("R3", "flag while disabled", {3'b0, flag}, 4'h0);

        // Enable, falling, single edge, timer link (pin high -> no side effect)
        wr(4'b1001, "R2");
        hold(3, 1'b1, "R4");
        check("R4", "no flag at inactive level", {3'b0, flag}, 4'h0);
        // R7 latency: fall at pin, level after 2 edges, flag after 3
        cyc(1'b0, 1'b0, 4'h0, 1'b0, "R7");
        check("R7", "level after 1 edge", {3'b0, level}, 4'h0);
        hold(1, 1'b0, "R7");
        check("R7", "level after 2 edges", {3'b0, level}, 4'h1);
        check("R7", "flag after 2 edges", {3'b0, flag}, 4'h0);
        hold(1, 1'b0, "R7");
        check("R7", "flag after 3 edges", {3'b0, flag}, 4'h1);
        check("R6", "start with flag", {3'b0, tstart}, 4'h1);
        hold(1, 1'b0, "R6");
        check("R6", "start one cycle only", {3'b0, tstart}, 4'h0);
        check("R8", "flag sticky", {3'b0, flag}, 4'h1);
        // Rising edge ignored in single falling mode
        clear("R8");
        check("R8", "flag cleared", {3'b0, flag}, 4'h0);
        hold(5, 1'b1, "R5");
        check("R5", "rising ignored in single mode", {3'b0, flag}, 4'h0);

        // Set and clear on the same edge: set wins
        cyc(1'b0, 1'b0, 4'h0, 1'b0, "R8");
        cyc(1'b0, 1'b0, 4'h0, 1'b0, "R8");
        cyc(1'b0, 1'b0, 4'h0, 1'b1, "R8");
        check("R8", "set wins over clear", {3'b0, flag}, 4'h1);
        clear("R8");

        // Polarity write side effect: pin low, switch to rising -> active drops (single mode, no set)
        wr(4'b1100, "R9");
        hold(2, 1'b0, "R9");
        check("R9", "1->0 single mode no set", {3'b0, flag}, 4'h0);
        // Back to falling with pin low -> active rises -> flag
        wr(4'b1000, "R9");
        hold(1, 1'b0, "R9");
        check("R9", "write-induced set", {3'b0, flag}, 4'h1);
        check("R6", "no start without link", {3'b0, tstart}, 4'h0);
        clear("R9");

        // Both-edge mode with link, rising polarity
        wr(4'b1111, "R5");
        hold(3, 1'b0, "R5"); clear("R5");
        hold(3, 1'b1, "R5");
        check("R5", "rising edge in both mode", {3'b0, flag}, 4'h1);
        clear("R5");
        hold(3, 1'b0, "R5");
        check("R5", "falling edge in both mode", {3'b0, flag}, 4'h1);
        clear("R5");

        // Disable write in both-edge mode from active level -> apparent edge
        hold(3, 1'b1, "R9"); clear("R9");
        wr(4'b0010, "R9");
        hold(1, 1'b1, "R9");
        check("R9", "disable edge in both mode", {3'b0, flag}, 4'h1);
        check("R3", "level off when disabled", {3'b0, level}, 4'h0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic p, w, c;
            logic [3:0] d;
            p = ($urandom % 4 == 0) ? ~pin : pin;
            w = ($urandom % 16 == 0);
            d = 4'($urandom);
            c = ($urandom % 6 == 0);
            cyc(p, w, d, c, "RND R2 R4 R5 R6 R8 R9");
        end

        // Retention: value held for many idle cycles until reset
        wr(4'b1010, "R2");
        hold(20, pin, "R2");
        check("R2", "retained", rd_data, 4'b1010);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1", "reset clears reg", rd_data, 4'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule